// File: doc/BRIEF.md
# Snooping Line-State Coherence Controller

This block keeps the coherence state of a small direct-mapped group of line tags that belong to one private cache sitting on a shared snooping bus. Each line is Invalid, Shared, Exclusive-clean or Modified. The local processor presents a read or a write for a line address. The block answers at once when the line already grants the access. Otherwise it places a bus request: a read, an intent-to-write, or the write-back of a dirty victim. It waits for the completion flag and then re-examines the held request. The data path is not modelled. Requests, completions and dirty-data supply are single flags.

At the same time the block watches every bus transaction issued by other agents. When another agent reads a line, this cache reports that it holds a copy. If that copy is dirty, the cache supplies the data itself instead of letting stale memory answer, and the line drops to Shared. When another agent announces an intent to write, the local copy is discarded. A parameter selects a compact two-bit valid/dirty storage form in which the clean-exclusive and dirty states collapse into a single owned state.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: no snoop sees a copy and the first local access to any address goes to the bus.
- R2: A local read whose tag is absent issues a bus read (op code 0) for that line address. When the fill returns with `bus_fill_excl` low, the line becomes Shared: it is readable, it is reported on a snoop, and it is not writable without a bus request.
- R3: A read fill returned with `bus_fill_excl` high leaves the line Exclusive-clean. A following local write completes with no bus request and makes the line Modified.
- R4: A local write to a line that is Invalid, Shared or holds another clean tag issues an intent-to-write (op code 1) for the written line address. On completion the line is Modified.
- R5: A local read or write that hits a Modified line is acknowledged in the cycle it is presented. It causes no bus request and the line stays Modified.
- R6: A snoop read (snoop op 0) that hits a Modified line raises `snp_intervene` in that cycle, and the line becomes Shared.
- R7: A snoop read that hits an Exclusive-clean line moves it to Shared without `snp_intervene`.
- R8: A snoop intent-to-write (snoop op 1) that hits any valid copy makes it Invalid, and raises `snp_intervene` when the copy was Modified.
- R9: `snp_shared` is high in the cycle of a snoop exactly when a valid line with the snooped tag is present.
- R10: A snoop and a local request to the same line in the same cycle are ordered snoop first. The local request is judged against the post-snoop state.
- R11: A miss whose indexed line holds a different tag in Modified first issues a write-back (op code 2) with the victim's line address. The victim becomes Invalid, and only then is the fill request issued.
- R12: With `VD_ENC` = 1, lines are stored as valid/dirty bits. A clean-exclusive fill is held as the owned dirty state, so a snoop read of it raises `snp_intervene`.
- R13: `lcl_ack` is high only while `lcl_valid` is high and no bus request is pending. The requester holds its request until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcl_valid | input | 1 | Local request present, held until acknowledged |
| lcl_write | input | 1 | 1 = local write, 0 = local read |
| lcl_addr | input | LINE_ADDR_W | Local line address (low IDX_W bits index the line) |
| lcl_ack | output | 1 | Local request satisfied this cycle |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_op | output | 2 | 0 read, 1 intent-to-write, 2 write-back |
| bus_req_addr | output | LINE_ADDR_W | Line address of the bus request |
| bus_done | input | 1 | Pending bus request completes this cycle |
| bus_fill_excl | input | 1 | With a read completion: no other cache holds the line |
| snp_valid | input | 1 | Another agent's bus transaction is observed |
| snp_op | input | 1 | 0 read, 1 intent-to-write |
| snp_addr | input | LINE_ADDR_W | Snooped line address |
| snp_shared | output | 1 | A valid copy of the snooped line is held here |
| snp_intervene | output | 1 | This cache supplies dirty data for the snooped line |

## Verification
The delicate overlap is a remote snoop and a local request landing on the same line in the same cycle. The bench provokes it by driving both at one falling edge. In one case a Modified line is written locally while another agent announces intent-to-write. The bench expects intervention, no acknowledge, and an intent-to-write request on the next cycle. In the other case an Exclusive-clean line is read locally while another agent reads it. The bench expects an immediate acknowledge with no intervention, followed by a write that needs an upgrade.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } coh_state_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_RDX = 2'd1,
    OP_WB  = 2'd2
  } bus_op_e;

  // valid/dirty packing: {v,d}
  function automatic logic [1:0] vd_pack(coh_state_e s);
    case (s)
      ST_I:    return 2'b00;
      ST_S:    return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic coh_state_e vd_unpack(logic [1:0] b);
    if (!b[1])     return ST_I;
    else if (b[0]) return ST_M;
    else           return ST_S;
  endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 8,
  parameter bit VD_ENC = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [(1<<IDX_W)-1:0]         we,
  input  coh_state_e [(1<<IDX_W)-1:0]   nxt_state,
  input  logic [(1<<IDX_W)-1:0][TAG_W-1:0] nxt_tag,
  output coh_state_e [(1<<IDX_W)-1:0]   cur_state,
  output logic [(1<<IDX_W)-1:0][TAG_W-1:0] cur_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0][1:0] bits_q;
  logic [LINES-1:0][1:0] bits_d;
  logic [LINES-1:0][TAG_W-1:0] tag_q;

  generate
    if (VD_ENC) begin : g_vd
      always_comb begin
        for (int i = 0; i < LINES; i++) begin
          bits_d[i]    = vd_pack(nxt_state[i]);
          cur_state[i] = vd_unpack(bits_q[i]);
        end
      end
    end else begin : g_full
      always_comb begin
        for (int i = 0; i < LINES; i++) begin
          bits_d[i]    = nxt_state[i];
          cur_state[i] = coh_state_e'(bits_q[i]);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      tag_q  <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (we[i]) begin
          bits_q[i] <= bits_d[i];
          tag_q[i]  <= nxt_tag[i];
        end
      end
    end
  end

  assign cur_tag = tag_q;

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int IDX_W       = 2,
  parameter int LINE_ADDR_W = 10
) (
  input  logic                          snp_valid,
  input  logic                          snp_op,
  input  logic [LINE_ADDR_W-1:0]        snp_addr,
  input  coh_state_e [(1<<IDX_W)-1:0]   cur_state,
  input  logic [(1<<IDX_W)-1:0][LINE_ADDR_W-IDX_W-1:0] cur_tag,
  output coh_state_e [(1<<IDX_W)-1:0]   post_state,
  output logic                          snp_shared,
  output logic                          snp_intervene
);
  localparam int TAG_W = LINE_ADDR_W - IDX_W;

  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  logic             s_hit;

  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[LINE_ADDR_W-1:IDX_W];
  assign s_hit = snp_valid && (cur_tag[s_idx] == s_tag) && (cur_state[s_idx] != ST_I);

  always_comb begin
    post_state    = cur_state;
    snp_shared    = s_hit;
    snp_intervene = s_hit && (cur_state[s_idx] == ST_M);
    if (s_hit) begin
      post_state[s_idx] = snp_op ? ST_I : ST_S;
    end
  end

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_pkg::*;
#(
  parameter int IDX_W       = 2,
  parameter int LINE_ADDR_W = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lcl_valid,
  input  logic                          lcl_write,
  input  logic [LINE_ADDR_W-1:0]        lcl_addr,
  output logic                          lcl_ack,
  input  coh_state_e [(1<<IDX_W)-1:0]   post_state,
  input  logic [(1<<IDX_W)-1:0][LINE_ADDR_W-IDX_W-1:0] cur_tag,
  output logic                          bus_req_valid,
  output logic [1:0]                    bus_req_op,
  output logic [LINE_ADDR_W-1:0]        bus_req_addr,
  input  logic                          bus_done,
  input  logic                          bus_fill_excl,
  output logic                          upd_en,
  output logic [IDX_W-1:0]              upd_idx,
  output coh_state_e                    upd_state,
  output logic [LINE_ADDR_W-IDX_W-1:0]  upd_tag
);
  localparam int TAG_W = LINE_ADDR_W - IDX_W;

  typedef enum logic {FS_IDLE = 1'b0, FS_BUSY = 1'b1} fsm_e;

  fsm_e                   fsm_q, fsm_d;
  bus_op_e                op_q, op_d;
  logic [LINE_ADDR_W-1:0] addr_q, addr_d;

  logic [IDX_W-1:0] l_idx;
  logic [TAG_W-1:0] l_tag;
  coh_state_e       l_st;
  logic             l_match;

  assign l_idx   = lcl_addr[IDX_W-1:0];
  assign l_tag   = lcl_addr[LINE_ADDR_W-1:IDX_W];
  assign l_st    = post_state[l_idx];
  assign l_match = (cur_tag[l_idx] == l_tag) && (l_st != ST_I);

  always_comb begin
    fsm_d         = fsm_q;
    op_d          = op_q;
    addr_d        = addr_q;
    lcl_ack       = 1'b0;
    upd_en        = 1'b0;
    upd_idx       = addr_q[IDX_W-1:0];
    upd_tag       = addr_q[LINE_ADDR_W-1:IDX_W];
    upd_state     = ST_I;
    bus_req_valid = (fsm_q == FS_BUSY);
    bus_req_op    = op_q;
    bus_req_addr  = addr_q;
    case (fsm_q)
      FS_IDLE: begin
        if (lcl_valid) begin
          if (l_match && !lcl_write) begin
            lcl_ack = 1'b1;
          end else if (l_match && (l_st == ST_E || l_st == ST_M)) begin
            lcl_ack = 1'b1;
            if (l_st == ST_E) begin
              upd_en    = 1'b1;
              upd_idx   = l_idx;
              upd_tag   = l_tag;
              upd_state = ST_M;
            end
          end else if (!l_match && l_st == ST_M) begin
            fsm_d  = FS_BUSY;
            op_d   = OP_WB;
            addr_d = {cur_tag[l_idx], l_idx};
          end else begin
            fsm_d  = FS_BUSY;
            op_d   = lcl_write ? OP_RDX : OP_RD;
            addr_d = lcl_addr;
          end
        end
      end
      default: begin
        if (bus_done) begin
          fsm_d  = FS_IDLE;
          upd_en = 1'b1;
          case (op_q)
            OP_WB:   upd_state = ST_I;
            OP_RDX:  upd_state = ST_M;
            default: upd_state = bus_fill_excl ? ST_E : ST_S;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= FS_IDLE;
      op_q   <= OP_RD;
      addr_q <= '0;
    end else begin
      fsm_q <= fsm_d;
      if (fsm_q == FS_IDLE) begin
        op_q   <= op_d;
        addr_q <= addr_d;
      end
    end
  end

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int IDX_W       = 2,
  parameter int LINE_ADDR_W = 10,
  parameter bit VD_ENC      = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lcl_valid,
  input  logic                   lcl_write,
  input  logic [LINE_ADDR_W-1:0] lcl_addr,
  output logic                   lcl_ack,
  output logic                   bus_req_valid,
  output logic [1:0]             bus_req_op,
  output logic [LINE_ADDR_W-1:0] bus_req_addr,
  input  logic                   bus_done,
  input  logic                   bus_fill_excl,
  input  logic                   snp_valid,
  input  logic                   snp_op,
  input  logic [LINE_ADDR_W-1:0] snp_addr,
  output logic                   snp_shared,
  output logic                   snp_intervene
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = LINE_ADDR_W - IDX_W;

  coh_state_e [LINES-1:0]          cur_state;
  coh_state_e [LINES-1:0]          post_state;
  coh_state_e [LINES-1:0]          nxt_state;
  logic [LINES-1:0][TAG_W-1:0]     cur_tag;
  logic [LINES-1:0][TAG_W-1:0]     nxt_tag;
  logic [LINES-1:0]                we;

  logic             upd_en;
  logic [IDX_W-1:0] upd_idx;
  coh_state_e       upd_state;
  logic [TAG_W-1:0] upd_tag;

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .VD_ENC(VD_ENC)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (we),
    .nxt_state (nxt_state),
    .nxt_tag   (nxt_tag),
    .cur_state (cur_state),
    .cur_tag   (cur_tag)
  );

  coh_snoop_unit #(.IDX_W(IDX_W), .LINE_ADDR_W(LINE_ADDR_W)) u_snoop (
    .snp_valid     (snp_valid),
    .snp_op        (snp_op),
    .snp_addr      (snp_addr),
    .cur_state     (cur_state),
    .cur_tag       (cur_tag),
    .post_state    (post_state),
    .snp_shared    (snp_shared),
    .snp_intervene (snp_intervene)
  );

  coh_req_fsm #(.IDX_W(IDX_W), .LINE_ADDR_W(LINE_ADDR_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .lcl_valid     (lcl_valid),
    .lcl_write     (lcl_write),
    .lcl_addr      (lcl_addr),
    .lcl_ack       (lcl_ack),
    .post_state    (post_state),
    .cur_tag       (cur_tag),
    .bus_req_valid (bus_req_valid),
    .bus_req_op    (bus_req_op),
    .bus_req_addr  (bus_req_addr),
    .bus_done      (bus_done),
    .bus_fill_excl (bus_fill_excl),
    .upd_en        (upd_en),
    .upd_idx       (upd_idx),
    .upd_state     (upd_state),
    .upd_tag       (upd_tag)
  );

  // Snoop result first, then the local or completion update on top.
  always_comb begin
    nxt_state = post_state;
    nxt_tag   = cur_tag;
    if (upd_en) begin
      nxt_state[upd_idx] = upd_state;
      nxt_tag[upd_idx]   = upd_tag;
    end
    for (int i = 0; i < LINES; i++) begin
      we[i] = (nxt_state[i] != cur_state[i]) || (nxt_tag[i] != cur_tag[i]);
    end
  end

endmodule

// File: rtl/coh_snoop_ctrl_chk.sv
module coh_snoop_ctrl_chk
  import coh_pkg::*;
#(
  parameter int IDX_W       = 2,
  parameter int LINE_ADDR_W = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lcl_valid,
  input logic                   lcl_write,
  input logic [LINE_ADDR_W-1:0] lcl_addr,
  input logic                   lcl_ack,
  input logic                   bus_req_valid,
  input logic [1:0]             bus_req_op,
  input logic [LINE_ADDR_W-1:0] bus_req_addr,
  input logic                   bus_done,
  input logic                   snp_valid,
  input logic                   snp_op,
  input logic [LINE_ADDR_W-1:0] snp_addr,
  input logic                   snp_shared,
  input logic                   snp_intervene,
  input coh_state_e [(1<<IDX_W)-1:0] cur_state
);
  logic [IDX_W-1:0] snp_idx_q, lcl_idx_q, bus_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snp_idx_q <= '0;
      lcl_idx_q <= '0;
      bus_idx_q <= '0;
    end else begin
      snp_idx_q <= snp_addr[IDX_W-1:0];
      lcl_idx_q <= lcl_addr[IDX_W-1:0];
      bus_idx_q <= bus_req_addr[IDX_W-1:0];
    end
  end

  // R13
  ack_only_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_ack |-> (lcl_valid && !bus_req_valid));

  // R9
  intervene_needs_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_intervene |-> (snp_shared && snp_valid));

  // R6
  remote_read_dirty_to_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_op && snp_intervene && !(bus_req_valid && bus_done))
    |=> (cur_state[snp_idx_q] == ST_S));

  // R8
  remote_intent_invalidates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op && snp_shared && !(bus_req_valid && bus_done))
    |=> (cur_state[snp_idx_q] == ST_I));

  // R5
  write_hit_leaves_modified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_ack && lcl_write) |=> (cur_state[lcl_idx_q] == ST_M));

  // R4
  intent_done_gives_modified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_done && bus_req_op == OP_RDX && !snp_valid)
    |=> (cur_state[bus_idx_q] == ST_M));

endmodule

bind coh_snoop_ctrl coh_snoop_ctrl_chk #(.IDX_W(IDX_W), .LINE_ADDR_W(LINE_ADDR_W)) u_chk (.*);

// File: tb/test_coh_snoop_ctrl.sv
module test_coh_snoop_ctrl;

  localparam int AW = 10;
  localparam logic [AW-1:0] A_ADR = 10'h041;
  localparam logic [AW-1:0] B_ADR = 10'h085;
  localparam logic [AW-1:0] C_ADR = 10'h102;
  localparam logic [AW-1:0] D_ADR = 10'h0C3;
  localparam logic [AW-1:0] E_ADR = 10'h010;

  logic clk, rst_n;
  logic lcl_valid, lcl_write, lcl_ack;
  logic [AW-1:0] lcl_addr;
  logic bus_req_valid, bus_done, bus_fill_excl;
  logic [1:0] bus_req_op;
  logic [AW-1:0] bus_req_addr;
  logic snp_valid, snp_op, snp_shared, snp_intervene;
  logic [AW-1:0] snp_addr;

  logic v_lv, v_lw, v_ack, v_bv, v_bd, v_bx, v_sv, v_so, v_ss, v_si;
  logic [AW-1:0] v_la, v_ba, v_sa;
  logic [1:0] v_bop;

  int n_chk, n_bad;

  coh_snoop_ctrl #(.IDX_W(2), .LINE_ADDR_W(AW), .VD_ENC(1'b0)) i_coh_snoop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lcl_valid(lcl_valid), .lcl_write(lcl_write), .lcl_addr(lcl_addr), .lcl_ack(lcl_ack),
    .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op), .bus_req_addr(bus_req_addr),
    .bus_done(bus_done), .bus_fill_excl(bus_fill_excl),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_intervene(snp_intervene)
  );

  coh_snoop_ctrl #(.IDX_W(2), .LINE_ADDR_W(AW), .VD_ENC(1'b1)) i_coh_snoop_ctrl_vd (
    .clk(clk), .rst_n(rst_n),
    .lcl_valid(v_lv), .lcl_write(v_lw), .lcl_addr(v_la), .lcl_ack(v_ack),
    .bus_req_valid(v_bv), .bus_req_op(v_bop), .bus_req_addr(v_ba),
    .bus_done(v_bd), .bus_fill_excl(v_bx),
    .snp_valid(v_sv), .snp_op(v_so), .snp_addr(v_sa),
    .snp_shared(v_ss), .snp_intervene(v_si)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic hit_req(input logic w, input logic [AW-1:0] a, input string req);
    @(negedge clk); lcl_valid = 1; lcl_write = w; lcl_addr = a;
    #1 chk(req, "hit ack", lcl_ack, 1);
    chk(req, "hit no bus req", bus_req_valid, 0);
    @(negedge clk); lcl_valid = 0;
    #1 chk(req, "no bus req after hit", bus_req_valid, 0);
  endtask

  task automatic miss_req(input logic w, input logic [AW-1:0] a, input int op,
                          input logic excl, input string req);
    @(negedge clk); lcl_valid = 1; lcl_write = w; lcl_addr = a;
    #1 chk(req, "miss ack low", lcl_ack, 0);
    @(negedge clk);
    #1 chk(req, "bus req valid", bus_req_valid, 1);
    chk(req, "bus op", bus_req_op, op);
    chk(req, "bus addr", bus_req_addr, a);
    bus_done = 1; bus_fill_excl = excl;
    @(negedge clk); bus_done = 0; bus_fill_excl = 0;
    #1 chk(req, "ack after fill", lcl_ack, 1);
    @(negedge clk); lcl_valid = 0;
  endtask

  task automatic snoop(input logic op, input logic [AW-1:0] a, input logic exp_sh,
                       input logic exp_iv, input string req);
    @(negedge clk); snp_valid = 1; snp_op = op; snp_addr = a;
    #1 chk(req, "snp_shared", snp_shared, exp_sh);
    chk(req, "snp_intervene", snp_intervene, exp_iv);
    @(negedge clk); snp_valid = 0;
  endtask

  task automatic t_reset();
    #1 chk("R1", "bus idle at reset", bus_req_valid, 0);
    chk("R1", "no ack at reset", lcl_ack, 0);
    snoop(0, A_ADR, 0, 0, "R1");
    snoop(0, D_ADR, 0, 0, "R1");
  endtask

  task automatic t_read_miss();
    miss_req(0, A_ADR, 0, 0, "R2");
    snoop(0, A_ADR, 1, 0, "R2");
    hit_req(0, A_ADR, "R2");
  endtask

  task automatic t_upgrade_and_hits();
    miss_req(1, A_ADR, 1, 0, "R4");
    hit_req(0, A_ADR, "R5");
    hit_req(1, A_ADR, "R5");
  endtask

  task automatic t_remote_dirty();
    snoop(0, A_ADR, 1, 1, "R6");
    miss_req(1, A_ADR, 1, 0, "R6");
    snoop(1, A_ADR, 1, 1, "R8");
    snoop(0, A_ADR, 0, 0, "R8");
  endtask

  task automatic t_exclusive();
    miss_req(0, C_ADR, 0, 1, "R3");
    hit_req(1, C_ADR, "R3");
    snoop(0, C_ADR, 1, 1, "R3");
    miss_req(0, D_ADR, 0, 1, "R7");
    snoop(0, D_ADR, 1, 0, "R7");
    miss_req(1, D_ADR, 1, 0, "R7");
    snoop(1, C_ADR, 1, 0, "R8");
    snoop(0, C_ADR, 0, 0, "R9");
  endtask

  task automatic t_same_cycle();
    // D is Modified: local write meets remote intent-to-write
    @(negedge clk);
    lcl_valid = 1; lcl_write = 1; lcl_addr = D_ADR;
    snp_valid = 1; snp_op = 1; snp_addr = D_ADR;
    #1 chk("R10", "intervene on collision", snp_intervene, 1);
    chk("R10", "no ack on collision", lcl_ack, 0);
    @(negedge clk); snp_valid = 0;
    #1 chk("R10", "re-request valid", bus_req_valid, 1);
    chk("R10", "re-request op", bus_req_op, 1);
    chk("R10", "re-request addr", bus_req_addr, D_ADR);
    bus_done = 1;
    @(negedge clk); bus_done = 0;
    #1 chk("R10", "ack after re-request", lcl_ack, 1);
    @(negedge clk); lcl_valid = 0;
    // E line: local read meets remote read
    miss_req(0, E_ADR, 0, 1, "R10");
    @(negedge clk);
    lcl_valid = 1; lcl_write = 0; lcl_addr = E_ADR;
    snp_valid = 1; snp_op = 0; snp_addr = E_ADR;
    #1 chk("R10", "read ack on collision", lcl_ack, 1);
    chk("R10", "clean line no intervene", snp_intervene, 0);
    chk("R10", "copy reported", snp_shared, 1);
    @(negedge clk); snp_valid = 0; lcl_valid = 0;
    miss_req(1, E_ADR, 1, 0, "R10");
  endtask

  task automatic t_victim();
    miss_req(1, A_ADR, 1, 0, "R4");
    @(negedge clk); lcl_valid = 1; lcl_write = 0; lcl_addr = B_ADR;
    #1 chk("R11", "no ack on conflict", lcl_ack, 0);
    @(negedge clk);
    #1 chk("R11", "write-back op", bus_req_op, 2);
    chk("R11", "write-back addr", bus_req_addr, A_ADR);
    bus_done = 1;
    @(negedge clk); bus_done = 0;
    #1 chk("R11", "no ack after write-back", lcl_ack, 0);
    @(negedge clk);
    #1 chk("R11", "fill op", bus_req_op, 0);
    chk("R11", "fill addr", bus_req_addr, B_ADR);
    bus_done = 1;
    @(negedge clk); bus_done = 0;
    #1 chk("R11", "ack after fill", lcl_ack, 1);
    @(negedge clk); lcl_valid = 0;
    snoop(0, A_ADR, 0, 0, "R11");
    snoop(0, B_ADR, 1, 0, "R11");
    miss_req(1, A_ADR, 1, 0, "R4");
  endtask

  task automatic t_vd();
    @(negedge clk); v_lv = 1; v_lw = 0; v_la = A_ADR;
    @(negedge clk);
    #1 chk("R12", "vd read request", v_bv, 1);
    chk("R12", "vd read op", v_bop, 0);
    v_bd = 1; v_bx = 1;
    @(negedge clk); v_bd = 0; v_bx = 0;
    #1 chk("R12", "vd fill ack", v_ack, 1);
    @(negedge clk); v_lv = 0; v_sv = 1; v_so = 0; v_sa = A_ADR;
    #1 chk("R12", "vd merged owned intervenes", v_si, 1);
    chk("R12", "vd copy reported", v_ss, 1);
    @(negedge clk); v_sv = 0; v_lv = 1; v_lw = 1; v_la = A_ADR;
    #1 chk("R12", "vd write after share misses", v_ack, 0);
    @(negedge clk);
    #1 chk("R12", "vd upgrade op", v_bop, 1);
    v_bd = 1;
    @(negedge clk); v_bd = 0;
    #1 chk("R13", "vd ack after upgrade", v_ack, 1);
    @(negedge clk); v_lv = 0;
    #1 chk("R13", "ack drops with request", v_ack, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 0;
    lcl_valid = 0; lcl_write = 0; lcl_addr = '0;
    bus_done = 0; bus_fill_excl = 0;
    snp_valid = 0; snp_op = 0; snp_addr = '0;
    v_lv = 0; v_lw = 0; v_la = '0; v_bd = 0; v_bx = 0;
    v_sv = 0; v_so = 0; v_sa = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_read_miss();
    t_upgrade_and_hits();
    t_remote_dirty();
    t_exclusive();
    t_same_cycle();
    t_victim();
    t_vd();
    finish_run();
  end

endmodule